// File: doc/BRIEF.md
# Cascaded Seven-Channel DMA Controller

This block arbitrates among eight DMA request lines and runs the address and count sequencing for whichever channel wins. It is built from two four-channel arbitration units. The lower unit serves channels 0 to 3. Its combined request occupies slot 4 of the upper unit, which also serves channels 5 to 7. Slot 4 is therefore the cascade link and never moves data itself, which leaves seven usable channels. Before it moves any data, the controller raises a hold request to the processor and waits for the hold acknowledge. Each transfer cycle appears on an abstract bus port: the address, the direction, the data size, the active channel, and a terminal-count strobe.

Software programs each channel through a write port. It sets the base address, the base count, and a three-bit mode. Writing a base value also loads the matching working (current) value. A count of N gives N+1 transfers. A session is never pre-empted: once a channel is granted, it keeps the bus until its session ends. In single mode a session ends after one transfer. In block mode it ends at terminal count.

Top module: `dma_cascade_ctrl`

## Requirements
- R1: After reset, `hold_req`, `xfer_valid` and `tc_pulse` are 0 and `ch_ack` is all zeros.
- R2: When a new session is granted, the winner is the lowest-numbered pending channel. The order is 0,1,2,3,5,6,7, from highest to lowest.
- R3: During a session the granted channel does not change, and at most one `ch_ack` bit is high. A request from any other channel, even a higher-priority one, waits until the session has ended.
- R4: A write with `cfg_sel`=0 sets the base and current address. A write with `cfg_sel`=1 sets the base and current count. Each transfer drives `xfer_addr` with the current address. The current address then increments by 1 and the current count decrements by 1.
- R5: The transfer issued while the current count is 0 is the last one of the session. `tc_pulse` is high in that same cycle, and in the next cycle `xfer_valid` and that channel's `ch_ack` are low. A programmed count of N therefore gives N+1 transfers.
- R6: No transfer happens unless both `hold_req` and `hold_ack` are high. `hold_req` rises once a request is granted and stays high until the session ends.
- R7: In single mode (mode bit 0 = 0), `hold_req` drops for at least one cycle after each transfer, and the channel must win arbitration again before its next transfer.
- R8: In block mode (mode bit 0 = 1), transfers occur on consecutive cycles while `hold_ack` is high. `hold_req` stays high until terminal count, even if the request line drops.
- R9: A request on channel 4 is ignored: it never raises `hold_req`, and `ch_ack[4]` is never asserted.
- R10: `xfer_word` is 0 (byte) for channels 0 to 3 and 1 (16-bit word) for channels 5 to 7.
- R11: `xfer_mem_to_io` equals mode bit 1. A value of 1 means a read (memory to I/O), and 0 means a write (I/O to memory).
- R12: With mode bit 2 set, terminal count reloads the current address and count from the base values. With it clear, the current address stays one past the last address used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 8 | Per-channel DMA request (bit 4 is the cascade slot) |
| ch_ack | output | 8 | Per-channel acknowledge, high in that channel's transfer cycles |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus hold granted by the processor |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 2 | 0 base address, 1 base count, 2 mode |
| cfg_data | input | DATA_W | Write data; mode uses bits [2:0] = {auto-init, mem-to-I/O, block} |
| xfer_valid | output | 1 | A transfer cycle is issued this clock |
| xfer_ch | output | 3 | Channel performing the transfer |
| xfer_addr | output | ADDR_W | Transfer address |
| xfer_mem_to_io | output | 1 | 1 read (memory to I/O), 0 write (I/O to memory) |
| xfer_word | output | 1 | 1 for a 16-bit word, 0 for a byte |
| tc_pulse | output | 1 | Terminal count reached on this transfer |

## Verification
The bench aims at four kinds of failure.
- **Pre-emption.** A higher-priority request is raised in the middle of a block session. A design that re-arbitrates would hand the bus to that request early. The bench checks that the running channel still owns every following transfer.
- **Count off by one.** Programmed counts of 0, 1, 2 and 3 are used. A design that mistimes terminal count would show the wrong number of transfers or put the terminal-count strobe on the wrong beat.
- **Cascade slot.** Channel 4 is requested on its own. A design that fails to mask it would raise hold or acknowledge channel 4.
- **Hold and auto-init.** In single mode, a design that keeps hold between transfers is caught. On a repeat request, a design that mixes up the auto-init reload with the plain post-terminal address returns the wrong starting address.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int UNIT_CH    = 4;
    localparam int NUM_CH     = 2 * UNIT_CH;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int UIDX_W     = $clog2(UNIT_CH);
    localparam int CASCADE_CH = UNIT_CH;
    localparam int MODE_W     = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_XFER = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CFG_BASE_ADDR = 2'd0,
        CFG_BASE_CNT  = 2'd1,
        CFG_MODE      = 2'd2
    } cfg_sel_e;

    // bit 0 block, bit 1 memory-to-I/O, bit 2 auto-init
    typedef struct packed {
        logic auto_init;
        logic mem_to_io;
        logic block;
    } ch_mode_t;

    function automatic logic is_word_ch(input logic [CH_W-1:0] ch);
        return ch >= CH_W'(CASCADE_CH);
    endfunction

endpackage

// File: rtl/dma_unit_arb.sv
module dma_unit_arb
    import dma_pkg::*;
(
    input  logic [UNIT_CH-1:0] req,
    output logic               valid,
    output logic [UIDX_W-1:0]  idx
);
    // Fixed priority: lowest index wins.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = UNIT_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = UIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output ch_mode_t          mode
);
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                CFG_BASE_ADDR: begin
                    base_addr <= wr_data[ADDR_W-1:0];
                    cur_addr  <= wr_data[ADDR_W-1:0];
                end
                CFG_BASE_CNT: begin
                    base_cnt <= wr_data[CNT_W-1:0];
                    cur_cnt  <= wr_data[CNT_W-1:0];
                end
                CFG_MODE: mode <= ch_mode_t'(wr_data[MODE_W-1:0]);
                default: ;
            endcase
        end else if (step) begin
            if (cur_cnt == '0 && mode.auto_init) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + ADDR_W'(1);
                cur_cnt  <= cur_cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [CH_W-1:0] req_ch,
    input  logic            hold_ack,
    input  logic            last,
    input  logic            block_mode,
    output logic            hold_req,
    output logic            fire,
    output logic [CH_W-1:0] grant_ch
);
    seq_state_e state;

    assign hold_req = (state != SEQ_IDLE);
    assign fire     = (state == SEQ_XFER) && hold_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            grant_ch <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (req_valid) begin
                    grant_ch <= req_ch;
                    state    <= SEQ_HOLD;
                end
                SEQ_HOLD: if (hold_ack) state <= SEQ_XFER;
                SEQ_XFER: if (fire && (last || !block_mode)) state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_cascade_ctrl.sv
module dma_cascade_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        ch_req,
    output logic [7:0]        ch_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              xfer_valid,
    output logic [2:0]        xfer_ch,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_mem_to_io,
    output logic              xfer_word,
    output logic              tc_pulse
);
    logic [ADDR_W-1:0] cur_addr_a [NUM_CH];
    logic [CNT_W-1:0]  cur_cnt_a  [NUM_CH];
    ch_mode_t          mode_a     [NUM_CH];

    logic [NUM_CH-1:0] req_eff;
    logic              sec_valid, pri_valid;
    logic [UIDX_W-1:0] sec_idx, pri_idx;
    logic [CH_W-1:0]   pick_ch, grant_ch;
    logic              fire, last;

    // The cascade slot carries the lower unit's request, not its own line.
    assign req_eff = ch_req & ~(NUM_CH'(1) << CASCADE_CH);

    dma_unit_arb sec_arb_i (
        .req   (req_eff[UNIT_CH-1:0]),
        .valid (sec_valid),
        .idx   (sec_idx)
    );

    dma_unit_arb pri_arb_i (
        .req   ({req_eff[NUM_CH-1:UNIT_CH+1], sec_valid}),
        .valid (pri_valid),
        .idx   (pri_idx)
    );

    assign pick_ch = (pri_idx == '0) ? {1'b0, sec_idx} : {1'b1, pri_idx};

    assign last = (cur_cnt_a[grant_ch] == '0);

    dma_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (pri_valid),
        .req_ch     (pick_ch),
        .hold_ack   (hold_ack),
        .last       (last),
        .block_mode (mode_a[grant_ch].block),
        .hold_req   (hold_req),
        .fire       (fire),
        .grant_ch   (grant_ch)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c == CASCADE_CH) begin : g_link
            assign cur_addr_a[c] = '0;
            assign cur_cnt_a[c]  = '0;
            assign mode_a[c]     = '0;
        end else begin : g_regs
            logic wr_en_c, step_c;
            assign wr_en_c = cfg_we && (cfg_ch == CH_W'(c));
            assign step_c  = fire && (grant_ch == CH_W'(c));
            dma_chan_regs #(
                .ADDR_W (ADDR_W),
                .CNT_W  (CNT_W),
                .DATA_W (DATA_W)
            ) regs_i (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (wr_en_c),
                .wr_sel   (cfg_sel),
                .wr_data  (cfg_data),
                .step     (step_c),
                .cur_addr (cur_addr_a[c]),
                .cur_cnt  (cur_cnt_a[c]),
                .mode     (mode_a[c])
            );
        end
    end

    assign ch_ack         = fire ? (NUM_CH'(1) << grant_ch) : '0;
    assign xfer_valid     = fire;
    assign xfer_ch        = grant_ch;
    assign xfer_addr      = cur_addr_a[grant_ch];
    assign xfer_mem_to_io = mode_a[grant_ch].mem_to_io;
    assign xfer_word      = is_word_ch(grant_ch);
    assign tc_pulse       = fire && last;
endmodule

// File: rtl/dma_cascade_ctrl_chk.sv
module dma_cascade_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        ch_ack,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              cfg_we,
    input logic              xfer_valid,
    input logic [2:0]        xfer_ch,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              tc_pulse
);
    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_ack));

    assert_same_channel_R3: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_ch == $past(xfer_ch)));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && $past(xfer_valid) && !$past(tc_pulse) && !$past(cfg_we))
        |-> (xfer_addr == $past(xfer_addr) + ADDR_W'(1)));

    assert_tc_in_xfer_R5: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |-> xfer_valid);

    assert_tc_ends_session_R5: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> (!xfer_valid && ch_ack == 8'h00));

    assert_hold_handshake_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (hold_req && hold_ack));

    assert_no_cascade_ack_R9: assert property (@(posedge clk) disable iff (rst)
        !ch_ack[4] && !(xfer_valid && xfer_ch == 3'd4));
endmodule

bind dma_cascade_ctrl dma_cascade_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ch_ack     (ch_ack),
    .hold_req   (hold_req),
    .hold_ack   (hold_ack),
    .cfg_we     (cfg_we),
    .xfer_valid (xfer_valid),
    .xfer_ch    (xfer_ch),
    .xfer_addr  (xfer_addr),
    .tc_pulse   (tc_pulse)
);

// File: tb/dma_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_cascade_ctrl_tb_top;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [7:0]        ch_req;
    logic [7:0]        ch_ack;
    logic              hold_req, hold_ack;
    logic              cfg_we;
    logic [2:0]        cfg_ch;
    logic [1:0]        cfg_sel;
    logic [DATA_W-1:0] cfg_data;
    logic              xfer_valid;
    logic [2:0]        xfer_ch;
    logic [ADDR_W-1:0] xfer_addr;
    logic              xfer_mem_to_io, xfer_word, tc_pulse;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    dma_cascade_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_ack(ch_ack),
        .hold_req(hold_req), .hold_ack(hold_ack),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .xfer_valid(xfer_valid), .xfer_ch(xfer_ch), .xfer_addr(xfer_addr),
        .xfer_mem_to_io(xfer_mem_to_io), .xfer_word(xfer_word), .tc_pulse(tc_pulse)
    );

    // {request mask, expected first channel (8 = no grant)}
    localparam logic [11:0] VEC [10] = '{
        {8'hFF, 4'd0}, {8'hFE, 4'd1}, {8'hF0, 4'd5}, {8'h10, 4'd8},
        {8'hE0, 4'd5}, {8'hC8, 4'd3}, {8'h80, 4'd7}, {8'h44, 4'd2},
        {8'h60, 4'd5}, {8'h0C, 4'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input int sel, input int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_ch   = 3'(ch);
        cfg_sel  = 2'(sel);
        cfg_data = DATA_W'(data);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic program_ch(input int ch, input int addr, input int cnt, input int mode);
        cfg_write(ch, 0, addr);
        cfg_write(ch, 1, cnt);
        cfg_write(ch, 2, mode);
    endtask

    task automatic wait_xfer(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (xfer_valid) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        bit ok;
        int n, drops;
        rst = 1'b1; ch_req = '0; hold_ack = 1'b1;
        cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 hold_req", int'(hold_req), 0);
        chk("R1 xfer_valid", int'(xfer_valid), 0);
        chk("R1 tc_pulse", int'(tc_pulse), 0);
        chk("R1 ch_ack", int'(ch_ack), 0);

        // every channel: base ch*16, count 0, single, auto-init
        for (int c = 0; c < 8; c++)
            if (c != 4) program_ch(c, c * 16, 0, 3'b100);

        // R2 / R9 / R10: arbitration table
        foreach (VEC[v]) begin
            ch_req = VEC[v][11:4];
            if (VEC[v][3:0] == 4'd8) begin
                repeat (8) @(negedge clk);
                chk("R9 hold_req with cascade only", int'(hold_req), 0);
                chk("R9 ch_ack with cascade only", int'(ch_ack), 0);
            end else begin
                wait_xfer(ok);
                chk("R2 grant seen", int'(ok), 1);
                chk("R2 granted channel", int'(xfer_ch), int'(VEC[v][3:0]));
                chk("R10 transfer size", int'(xfer_word), int'(VEC[v][3:0] >= 4'd5));
                chk("R4 address", int'(xfer_addr), int'(VEC[v][3:0]) * 16);
                chk("R5 tc on count 0", int'(tc_pulse), 1);
            end
            ch_req = '0;
            settle();
        end

        // R6: hold handshake
        hold_ack = 1'b0;
        ch_req = 8'h04;
        repeat (5) @(negedge clk);
        chk("R6 hold_req raised", int'(hold_req), 1);
        chk("R6 no transfer without hold_ack", int'(xfer_valid), 0);
        hold_ack = 1'b1;
        wait_xfer(ok);
        chk("R6 transfer after hold_ack", int'(ok), 1);
        chk("R6 channel", int'(xfer_ch), 2);
        ch_req = '0;
        settle();

        // R8 / R11 / R5: block mode ch1, count 3, read
        program_ch(1, 16'h100, 3, 3'b011);
        ch_req = 8'h02;
        wait_xfer(ok);
        chk("R8 first addr", int'(xfer_addr), 16'h100);
        chk("R11 direction read", int'(xfer_mem_to_io), 1);
        chk("R5 no early tc", int'(tc_pulse), 0);
        ch_req = '0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R8 back-to-back", int'(xfer_valid), 1);
            chk("R8 hold kept", int'(hold_req), 1);
            chk("R4 block addr", int'(xfer_addr), 16'h100 + k);
            chk("R5 tc position", int'(tc_pulse), int'(k == 3));
        end
        @(negedge clk);
        chk("R5 session over", int'(xfer_valid), 0);
        chk("R5 ack dropped", int'(ch_ack), 0);
        settle();

        // R3: no pre-emption of a block session on ch6
        program_ch(6, 16'h300, 3, 3'b001);
        ch_req = 8'h40;
        wait_xfer(ok);
        chk("R3 ch6 first", int'(xfer_ch), 6);
        ch_req = 8'h01;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R3 still ch6", int'(xfer_ch), 6);
            chk("R3 still transferring", int'(xfer_valid), 1);
        end
        wait_xfer(ok);
        chk("R3 pending ch0 served", int'(xfer_ch), 0);
        ch_req = '0;
        settle();

        // R7 / R11: single mode ch5, count 2, write, no auto-init
        program_ch(5, 16'h200, 2, 3'b000);
        ch_req = 8'h20;
        n = 0; drops = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (xfer_valid) begin
                chk("R7 single addr", int'(xfer_addr), 16'h200 + n);
                chk("R11 direction write", int'(xfer_mem_to_io), 0);
                chk("R10 word channel", int'(xfer_word), 1);
                chk("R5 single tc", int'(tc_pulse), int'(n == 2));
                n++;
                if (tc_pulse) break;
            end else if (n > 0 && !hold_req) begin
                drops++;
            end
        end
        ch_req = '0;
        chk("R7 transfer count", n, 3);
        chk("R7 hold released between transfers", drops, 2);
        settle();
        ch_req = 8'h20;
        wait_xfer(ok);
        chk("R12 no reload without auto-init", int'(xfer_addr), 16'h203);
        ch_req = '0;
        settle();

        // R12: auto-init block ch3, count 1
        program_ch(3, 16'h50, 1, 3'b101);
        for (int r = 0; r < 2; r++) begin
            ch_req = 8'h08;
            wait_xfer(ok);
            chk("R12 start addr after reload", int'(xfer_addr), 16'h50);
            ch_req = '0;
            @(negedge clk);
            chk("R12 second addr", int'(xfer_addr), 16'h51);
            chk("R12 tc", int'(tc_pulse), 1);
            settle();
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule